// File: doc/BRIEF.md
# Arbitrated Serial EEPROM Bit-Bang Port

This block lets host software drive an external one-bit serial EEPROM by toggling bits in a single control register. The EEPROM pins are shared with a memory port that has other clients, so software first sets a request bit. The block then waits for the memory port to go idle and takes the pins. Once it owns them, the chip-select, clock and data-out register bits drive the EEPROM pins directly. The EEPROM data-in pin is synchronised and can be read back as a register bit.

A ready bit tells software when it may proceed. The first time it rises, it reports that the pins have been granted, and it carries no timing meaning. After that, every register write made while the pins are held drops ready. Ready comes back after a fixed delay of 800 ns, counted in clock cycles. Software uses this as a pacing timer for the EEPROM serial protocol, which runs entirely in software. Clearing the request bit hands the pins back and parks them low.

Top module: `seep_port`

## Requirements
- R1: After reset the read value is 0x00, the pins eeCs, eeSck and eeDo are low, and memGrant is low.
- R2: Bit 0 of a write is the request bit, and it reads back in bit 0. While the request is held and not yet granted, the grant (memGrant) is taken at the first clock edge at which memBusy is low. No grant is taken while memBusy is high.
- R3: On the first grant, the ready bit (read bit 1) goes high at the same edge as memGrant.
- R4: While granted, eeCs, eeSck and eeDo follow write bits 2, 3 and 4 of the most recent write from that write's clock edge. The stored values read back in bits 2, 3 and 4.
- R5: While not granted, eeCs, eeSck and eeDo stay low whatever bits 2 to 4 hold.
- R6: A write with bit 0 set, made while granted, clears ready at its edge. Ready returns high exactly DELAY_CYC clock edges later. DELAY_CYC is CLK_MHZ*DELAY_NS/1000, which is 200 with the default parameters.
- R7: While granted, eeDi shows in read bit 5 two clock edges after it changes. While not granted, bit 5 reads 0.
- R8: A write with bit 0 clear releases the pins at that edge. memGrant, ready and the three pins go low, and a request still waiting is cancelled. Read bits 6 and 7 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write value |
| regRdData | output | 8 | Control register read value |
| memBusy | input | 1 | Memory port serving another client |
| memGrant | output | 1 | Pins currently owned by the EEPROM path |
| eeCs | output | 1 | EEPROM chip select |
| eeSck | output | 1 | EEPROM serial clock |
| eeDo | output | 1 | EEPROM data out (to the EEPROM) |
| eeDi | input | 1 | EEPROM data in (from the EEPROM) |

## Verification
Three cases of arbitration are tried:
- memBusy held high for many cycles,
- memBusy dropped for a single cycle,
- a request withdrawn before memBusy falls.

Together these separate "grant on the first idle edge" from "grant eventually" and from "grant after cancel". All eight combinations of chip select, clock and data out are swept while granted. Each combination checks the pins, the readback and the exact ready delay, which tells a correct 200-edge count apart from an off-by-one count. Toggling eeDi both while granted and while released separates the two-stage synchroniser latency from gating of the read bit.

// File: rtl/seep_pkg.sv
package seep_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_REQ = 0;
  localparam int BIT_RDY = 1;
  localparam int BIT_CS  = 2;
  localparam int BIT_SCK = 3;
  localparam int BIT_DO  = 4;
  localparam int BIT_DI  = 5;

  typedef struct packed {
    logic pinEnable;
    logic ready;
  } seepCtrl_t;
endpackage

// File: rtl/seep_ctrl.sv
module seep_ctrl
  import seep_pkg::*;
#(
  parameter int DELAY_CYC = 200
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      wrReq,
  input  logic      memBusy,
  output logic      reqHeld,
  output seepCtrl_t ctrlOut
);
  localparam int TW = $clog2(DELAY_CYC + 1);
  localparam logic [TW-1:0] DELAY_LOAD = TW'(DELAY_CYC);

  logic          reqQ;
  logic          grantQ;
  logic [TW-1:0] timerQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqQ <= 1'b0;
    else if (wrEn) reqQ <= wrReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) grantQ <= 1'b0;
    else if (wrEn && !wrReq) grantQ <= 1'b0;
    else if (reqQ && !grantQ && !memBusy) grantQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timerQ <= '0;
    else if (wrEn && wrReq && grantQ) timerQ <= DELAY_LOAD;
    else if (!grantQ) timerQ <= '0;
    else if (timerQ != '0) timerQ <= timerQ - 1'b1;
  end

  assign reqHeld           = reqQ;
  assign ctrlOut.pinEnable = grantQ;
  assign ctrlOut.ready     = grantQ && (timerQ == '0);

  p_grant_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantQ) |-> ($past(!memBusy) && $past(reqQ)));
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqQ && !grantQ && memBusy) |=> !grantQ);
  p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrReq && grantQ) |=> !ctrlOut.ready);
  p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    timerQ <= DELAY_LOAD);
  p_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrReq) |=> (!grantQ && !ctrlOut.ready));
endmodule

// File: rtl/seep_dpath.sv
module seep_dpath
  import seep_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrCs,
  input  logic             wrSck,
  input  logic             wrDo,
  input  logic             reqHeld,
  input  seepCtrl_t        ctrlIn,
  input  logic             eeDi,
  output logic             eeCs,
  output logic             eeSck,
  output logic             eeDo,
  output logic [REG_W-1:0] rdData
);
  logic csQ, sckQ, doQ;
  logic diMeta, diSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ  <= 1'b0;
      sckQ <= 1'b0;
      doQ  <= 1'b0;
    end else if (wrEn) begin
      csQ  <= wrCs;
      sckQ <= wrSck;
      doQ  <= wrDo;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diMeta <= 1'b0;
      diSync <= 1'b0;
    end else begin
      diMeta <= eeDi;
      diSync <= diMeta;
    end
  end

  assign eeCs  = csQ  & ctrlIn.pinEnable;
  assign eeSck = sckQ & ctrlIn.pinEnable;
  assign eeDo  = doQ  & ctrlIn.pinEnable;

  always_comb begin
    rdData          = '0;
    rdData[BIT_REQ] = reqHeld;
    rdData[BIT_RDY] = ctrlIn.ready;
    rdData[BIT_CS]  = csQ;
    rdData[BIT_SCK] = sckQ;
    rdData[BIT_DO]  = doQ;
    rdData[BIT_DI]  = diSync & ctrlIn.pinEnable;
  end

  p_pins_parked_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.pinEnable |-> (!eeCs && !eeSck && !eeDo));
  p_di_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.pinEnable |-> !rdData[BIT_DI]);
  p_ready_owned_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.ready |-> ctrlIn.pinEnable);
endmodule

// File: rtl/seep_port.sv
module seep_port
  import seep_pkg::*;
#(
  parameter int CLK_MHZ  = 250,
  parameter int DELAY_NS = 800
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             memBusy,
  output logic             memGrant,
  output logic             eeCs,
  output logic             eeSck,
  output logic             eeDo,
  input  logic             eeDi
);
  localparam int DELAY_CYC = CLK_MHZ * DELAY_NS / 1000;

  seepCtrl_t ctrlBus;
  logic      reqHeld;

  seep_ctrl #(.DELAY_CYC(DELAY_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrReq(regWrData[BIT_REQ]),
    .memBusy(memBusy), .reqHeld(reqHeld), .ctrlOut(ctrlBus)
  );

  seep_dpath dpath_i (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn),
    .wrCs(regWrData[BIT_CS]), .wrSck(regWrData[BIT_SCK]), .wrDo(regWrData[BIT_DO]),
    .reqHeld(reqHeld), .ctrlIn(ctrlBus), .eeDi(eeDi),
    .eeCs(eeCs), .eeSck(eeSck), .eeDo(eeDo), .rdData(regRdData)
  );

  assign memGrant = ctrlBus.pinEnable;

  logic unusedBits;
  assign unusedBits = ^{regWrData[7:5], regWrData[BIT_RDY]};
endmodule

// File: tb/seep_port_tb_top.sv
module seep_port_tb_top;
  localparam int DELAY = 250 * 800 / 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic memBusy = 1'b1;
  logic memGrant, eeCs, eeSck, eeDo;
  logic eeDi = 1'b0;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  seep_port dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .memBusy(memBusy), .memGrant(memGrant),
    .eeCs(eeCs), .eeSck(eeSck), .eeDo(eeDo), .eeDi(eeDi)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = v;
    @(posedge clk);
    #1;
    regWrEn = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic waitReady(input string req);
    int n = 0;
    while (!regRdData[1] && n < DELAY + 10) begin
      step();
      n++;
    end
    chk(req, n, DELAY);
  endtask

  task automatic run();
    repeat (3) step();
    rstN = 1'b1;
    step();
    chk("R1 read", regRdData, 0);
    chk("R1 pins", {memGrant, eeCs, eeSck, eeDo}, 0);

    // R2: busy holds grant off
    wr(8'h01);
    repeat (5) step();
    chk("R2 wait grant", memGrant, 0);
    chk("R2 read req", regRdData, 8'h01);
    // R5: pin bits while waiting
    wr(8'h1D);
    chk("R5 pins low waiting", {eeCs, eeSck, eeDo}, 0);
    chk("R4 readback waiting", regRdData, 8'h1D);
    // R2/R3: grant at first idle edge, ready at once
    @(negedge clk);
    memBusy = 1'b0;
    step();
    chk("R2 grant", memGrant, 1);
    chk("R3 ready on grant", regRdData[1], 1);
    chk("R4 pins", {eeCs, eeSck, eeDo}, 3'b111);

    // R4/R6 sweep over all pin combinations
    for (int v = 0; v < 8; v++) begin
      logic [7:0] w;
      w = {3'b000, v[2:0], 2'b01};
      wr(w);
      chk("R6 ready cleared", regRdData[1], 0);
      chk("R4 pins sweep", {eeDo, eeSck, eeCs}, v);
      chk("R4 readback sweep", regRdData & 8'hFD, w);
      waitReady("R6 delay");
    end

    // R7: synchroniser latency
    @(negedge clk);
    eeDi = 1'b1;
    step();
    chk("R7 di one edge", regRdData[5], 0);
    step();
    chk("R7 di two edges", regRdData[5], 1);
    @(negedge clk);
    eeDi = 1'b0;
    step();
    chk("R7 di fall one edge", regRdData[5], 1);
    step();
    chk("R7 di fall two edges", regRdData[5], 0);

    // R8: release
    @(negedge clk);
    eeDi = 1'b1;
    wr(8'h1C);
    chk("R8 release grant", memGrant, 0);
    chk("R8 release pins", {eeCs, eeSck, eeDo}, 0);
    chk("R8 release read", regRdData, 8'h1C);
    step();
    step();
    chk("R7 di gated", regRdData[5], 0);

    // R2: single idle cycle grants
    @(negedge clk);
    memBusy = 1'b1;
    wr(8'h05);
    repeat (4) step();
    chk("R2 busy hold", memGrant, 0);
    @(negedge clk);
    memBusy = 1'b0;
    @(negedge clk);
    memBusy = 1'b1;
    #1;
    chk("R2 one idle cycle grant", memGrant, 1);
    chk("R3 ready immediate", regRdData[1], 1);
    chk("R4 cs after grant", eeCs, 1);
    wr(8'h00);

    // R8: cancel a waiting request
    wr(8'h01);
    wr(8'h00);
    @(negedge clk);
    memBusy = 1'b0;
    repeat (3) step();
    chk("R8 cancel", memGrant, 0);
    chk("R8 upper bits", regRdData[7:6], 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule